// File: doc/BRIEF.md
# Fixed One-Third Sample Scaler

This block multiplies an unsigned sample by the fixed fraction 85/256 (about 0.332), a cheap stand-in for division by three in gain and averaging paths. No multiplier is used. The constant 85 is binary 01010101, and instead of four shifted copies of the input summed by three adders, the block first forms five times the input with one adder, then adds that partial sum to itself shifted by four places, giving 85 times the input with two adders. Dropping the low eight bits of that sum yields the scaled sample, truncated toward zero.

A sample is offered with a valid strobe. One clock later the scaled sample appears with its own valid strobe. The internal sum is kept seven bits wider than the sample so that no bit is lost before the final eight-bit right shift, and the result has the same width as the input. The output register only loads when a sample is offered, so the last result stays on the output between samples.

Top module: `csm_third_scaler`

## Requirements
- R1: For every sample x accepted with in_valid high, out_data on the following cycle equals floor(x*85/256), with x and the result both unsigned DATA_W-bit values.
- R2: out_valid is high exactly in the cycle after a cycle with in_valid high and low after a cycle with in_valid low (one cycle of latency).
- R3: When in_valid is low, out_data keeps its previous value whatever in_data carries.
- R4: While rst_n is low, out_valid and out_data are zero.
- R5: The full-scale input (all ones) gives floor((2^DATA_W-1)*85/256) with no wrap of the internal sum; for DATA_W=16 that is 21759.
- R6: Inputs 0 to 3 give 0 and input 4 gives 1, the boundary of the truncation.
- R7: A result never exceeds the sample it came from.
- R8: Back-to-back samples on consecutive cycles each produce their own correct result in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe; loads the output register |
| in_data | input | DATA_W | Unsigned input sample |
| out_valid | output | 1 | Result strobe, in_valid delayed one cycle |
| out_data | output | DATA_W | Scaled sample, floor(in_data*85/256) |

## Verification
Every input whose upper byte is zero is swept and compared against floor(x*85/256), then random full-width samples, streamed back to back so a design that stalled or skipped a cycle would show misaligned results. The truncation boundary between 3 and 4 catches a design that rounds or adds a bias, and the all-ones input catches an internal sum kept too narrow, which would wrap and give a small wrong value. Idle cycles with changing in_data catch an output register that loads without a valid strobe.

// File: rtl/csm_pkg.sv
package csm_pkg;
  // Extra bits carried by the internal sum: 85 < 2**7.
  localparam int unsigned GUARD_W    = 7;
  // Fractional bits removed at the end: denominator 256.
  localparam int unsigned FRAC_W     = 8;
  // Number of shift-and-add stages that build the constant.
  localparam int unsigned NUM_STAGES = 2;
  // The constant realised: (1 + 2**2) * (1 + 2**4) = 85.
  localparam int unsigned SCALE_NUM  = 85;

  function automatic int unsigned stage_shift(input int unsigned idx);
    // Stage 0 forms 5x, stage 1 forms 5x*17 = 85x.
    return (idx == 0) ? 2 : 4;
  endfunction
endpackage

// File: rtl/csm_shift_add.sv
module csm_shift_add #(
  parameter int unsigned SUM_W = 23,
  parameter int unsigned SHIFT = 2
) (
  input  logic [SUM_W-1:0] term_in,
  output logic [SUM_W-1:0] sum_out
);
  // One adder: term + term shifted left.
  always_comb begin
    sum_out = term_in + (term_in << SHIFT);
  end
endmodule

// File: rtl/csm_out_reg.sv
module csm_out_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data
);
  logic [DATA_W-1:0] data_nxt;
  logic              valid_nxt;

  always_comb begin
    valid_nxt = load_en;
    data_nxt  = q_data;
    if (load_en) begin
      data_nxt = load_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else begin
      q_valid <= valid_nxt;
      q_data  <= data_nxt;
    end
  end
endmodule

// File: rtl/csm_third_scaler.sv
module csm_third_scaler #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  import csm_pkg::*;

  localparam int unsigned SUM_W = DATA_W + GUARD_W;

  logic [SUM_W-1:0]  stage_val [NUM_STAGES+1];
  logic [SUM_W-1:0]  scaled_full;
  logic [DATA_W-1:0] scaled;

  assign stage_val[0] = SUM_W'(in_data);

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    csm_shift_add #(
      .SUM_W (SUM_W),
      .SHIFT (stage_shift(g))
    ) i_stage (
      .term_in (stage_val[g]),
      .sum_out (stage_val[g+1])
    );
  end

  always_comb begin
    scaled_full = stage_val[NUM_STAGES] >> FRAC_W;
    scaled      = scaled_full[DATA_W-1:0];
  end

  csm_out_reg #(
    .DATA_W (DATA_W)
  ) i_out_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (in_valid),
    .load_data (scaled),
    .q_valid   (out_valid),
    .q_data    (out_data)
  );
endmodule

// File: rtl/csm_third_scaler_chk.sv
module csm_third_scaler_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  localparam int unsigned PROD_W = DATA_W + 8;

  logic [PROD_W-1:0] ref_prod;
  assign ref_prod = (PROD_W'(in_data) * PROD_W'(85)) >> 8;

  // R1: result of an accepted sample
  a_r1_value: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_data == $past(ref_prod[DATA_W-1:0])));

  // R2: valid follows valid by one cycle
  a_r2_valid_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_low: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3: output holds while idle
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  // R7: never larger than the source sample
  a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_data <= $past(in_data)));
endmodule

bind csm_third_scaler csm_third_scaler_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_csm_third_scaler.sv
module test_csm_third_scaler;
  localparam int unsigned W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] in_data;
  logic         out_valid;
  logic [W-1:0] out_data;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csm_third_scaler #(.DATA_W(W)) i_csm_third_scaler (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic logic [W-1:0] expect_of(input logic [W-1:0] x);
    longint unsigned p;
    p = (longint'(x) * 85) / 256;
    return W'(p);
  endfunction

  task automatic check(input string req, input longint unsigned act,
                       input longint unsigned exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive x on a falling edge; after the next falling edge the result of x is visible.
  task automatic stream_check(input logic [W-1:0] x, input string req);
    in_valid = 1'b1;
    in_data  = x;
    @(negedge clk);
    check({req, " data"}, out_data, expect_of(x));
    check("R2 valid", out_valid, 1);
  endtask

  initial begin
    logic [W-1:0] held;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (3) @(negedge clk);
    // R4: reset state, with a sample offered during reset
    in_valid = 1'b1;
    in_data  = 16'h1234;
    @(negedge clk);
    check("R4 valid", out_valid, 0);
    check("R4 data", out_data, 0);
    in_valid = 1'b0;
    rst_n    = 1'b1;
    @(negedge clk);
    check("R2 idle", out_valid, 0);

    // R6: truncation boundary
    stream_check(16'd3, "R6");
    stream_check(16'd4, "R6");
    stream_check(16'd0, "R6");

    // R5: full-scale input
    stream_check(16'hFFFF, "R5");
    check("R5 value", out_data, 21759);

    // R1 and R8: every byte-wide input, back to back
    for (int i = 0; i < 256; i++) begin
      stream_check(W'(i), "R1 R8 sweep");
    end

    // R3: idle with changing input data
    held     = out_data;
    in_valid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      in_data = W'($urandom);
      @(negedge clk);
      check("R3 hold", out_data, held);
      check("R2 low", out_valid, 0);
    end

    // R1, R7, R8: random full-width samples, back to back
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] x;
      x = W'($urandom);
      stream_check(x, "R1 R8 random");
      n_checks++;
      if (out_data > x) begin
        n_errors++;
        $display("FAIL R7: actual=%0d expected<=%0d", out_data, x);
      end
    end

    // R8: alternating valid and idle cycles
    for (int i = 0; i < 50; i++) begin
      logic [W-1:0] x;
      x = W'($urandom);
      stream_check(x, "R8 gapped");
      in_valid = 1'b0;
      in_data  = ~x;
      @(negedge clk);
      check("R3 gapped", out_data, expect_of(x));
      check("R2 gapped", out_valid, 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule